// File: doc/BRIEF.md
# Four-Phase FM Envelope Generator

This block produces the 10-bit attenuation envelope for a bank of time-multiplexed FM operators. Each operator keeps a phase (attack, decay, sustain, release) and an attenuation value in a small register array inside the block. An external slot sequencer presents one operator index at a time with an update strobe. In that cycle the block reads the operator's state, applies any key event or one envelope step, writes the result back, and registers the new attenuation on its outputs.

Every rate is key-scaled from the channel keycode and then gated by a shared global envelope counter. A slow rate only advances on counter values whose low bits are zero. The size of each step comes from an eight-entry increment pattern picked by the effective rate. Attack closes in on zero attenuation exponentially. Decay, sustain and release add the increment linearly and stop at full attenuation.

Top module: `fm_env_gen`

## Requirements
- R1: After reset every operator is in release (phase code 3) at attenuation 1023. The output register shows attenuation 1023, phase 3 and out_valid low. Phase codes are attack 0, decay 1, sustain 2 and release 3.
- R2: A strobe in cycle t for operator upd_op updates only that operator. In cycle t+1 out_valid is high, out_op equals upd_op, and env_out/out_phase hold the operator's written-back state. With no strobe, out_valid is low and env_out keeps its value.
- R3: A raw 5-bit rate of 0 gives an effective rate of 0. Any other raw rate R gives min(2*R + (keycode >> (3 - ks_sel)), 63).
- R4: With S = (47 - rate) >> 2 for effective rates below 48, and S = 0 otherwise, a step happens only when the low S bits of env_cnt are all zero. When they are not, attenuation is unchanged.
- R5: The increment is entry (env_cnt >> S) & 7 of the rate's pattern. The patterns are:
  - Rates 0 and 1 give 0.
  - Rates 60 and up give 8.
  - Rates 8..47 use lo[rate%4], where lo0={0,1,0,1,0,1,0,1}, lo1={0,1,0,1,1,1,0,1}, lo2={0,1,1,1,0,1,1,1} and lo3={0,1,1,1,1,1,1,1}.
  - Rates 2..7 use lo2 when rate bits [2:1] are 11, and lo0 otherwise.
  - Rates 48..59 use hi[rate%4] shifted left by (rate-48)>>2, where hi0={1,1,1,1,1,1,1,1}, hi1={1,1,1,2,1,1,1,2}, hi2={1,2,1,2,1,2,1,2} and hi3={1,2,2,2,1,2,2,2}.
- R6: In attack with a nonzero increment inc, attenuation becomes env - ((env*inc)>>4) - 1, floored at 0. An attack slot that ends at 0 moves the operator to decay.
- R7: In decay, sustain and release the increment is added and the result saturates at 1023.
- R8: The sustain level is the 4-bit field times 32, and field 15 means 1023. A decay operator whose attenuation is at or above that level switches to sustain at the start of its slot, and that slot uses the sustain rate.
- R9: The release raw rate is the 4-bit release field times 2 plus 1.
- R10: Key-off moves the operator to release with attenuation unchanged. Key-on enters attack with attenuation unchanged. If the key-scaled attack rate is 62 or more, key-on instead sets attenuation to 0 and enters decay. Key-on takes priority when both keys are given. A slot that carries a key event performs no envelope step.
- R11: Operators are independent: updating one never alters the stored state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Update strobe for the operator on upd_op |
| upd_op | input | OP_W | Operator index serviced this cycle |
| key_on | input | 1 | Key-on event for the serviced operator |
| key_off | input | 1 | Key-off event for the serviced operator |
| atk_rate | input | 5 | Raw attack rate |
| dec_rate | input | 5 | Raw decay rate |
| sus_rate | input | 5 | Raw sustain rate |
| rel_field | input | 4 | Release rate field |
| sus_field | input | 4 | Sustain level field |
| ks_sel | input | 2 | Key-scaling select |
| keycode | input | 5 | Channel keycode (block*4 + note code) |
| env_cnt | input | CNT_W | Shared global envelope counter |
| env_out | output | 10 | Attenuation of the last serviced operator |
| out_phase | output | 2 | Phase code of the last serviced operator |
| out_op | output | OP_W | Index of the last serviced operator |
| out_valid | output | 1 | High the cycle after a strobe |

## Verification
Any corrupted phase or attenuation in an operator's slot shows up on env_out one cycle after that operator's next strobe. Only the serviced operator's value is visible, so a bad write into a different slot stays hidden until that slot is strobed again. Two kinds of error can stay silent for many strobes: a wrong gating shift or a wrong pattern entry. They show only on counter values whose low bits line up with the rate. For that reason the comparison runs against a reference model on every strobe with a sweeping counter, alongside directed cases at the exact counter values.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

   localparam int ENV_W = 10;
   localparam logic [ENV_W-1:0] ENV_MAX = '1;

   typedef enum logic [1:0] {
      PH_ATK = 2'd0,
      PH_DEC = 2'd1,
      PH_SUS = 2'd2,
      PH_REL = 2'd3
   } env_phase_t;

   // low-range patterns, bit k = entry k (value 0 or 1)
   function automatic logic [7:0] lo_mask(input logic [1:0] sel);
      case (sel)
         2'd0:    lo_mask = 8'b1010_1010;
         2'd1:    lo_mask = 8'b1011_1010;
         2'd2:    lo_mask = 8'b1110_1110;
         default: lo_mask = 8'b1111_1110;
      endcase
   endfunction

   // high-range patterns, bit k set means entry k is 2 instead of 1
   function automatic logic [7:0] hi_mask(input logic [1:0] sel);
      case (sel)
         2'd0:    hi_mask = 8'b0000_0000;
         2'd1:    hi_mask = 8'b1000_1000;
         2'd2:    hi_mask = 8'b1010_1010;
         default: hi_mask = 8'b1110_1110;
      endcase
   endfunction

   function automatic logic [3:0] rate_inc(input logic [5:0] r, input logic [2:0] k);
      logic [7:0] m;
      logic [3:0] base;
      if (r < 6'd2) begin
         rate_inc = 4'd0;
      end else if (r >= 6'd60) begin
         rate_inc = 4'd8;
      end else if (r < 6'd8) begin
         m = lo_mask((r[2:1] == 2'b11) ? 2'd2 : 2'd0);
         rate_inc = {3'b000, m[k]};
      end else if (r < 6'd48) begin
         m = lo_mask(r[1:0]);
         rate_inc = {3'b000, m[k]};
      end else begin
         m = hi_mask(r[1:0]);
         base = 4'd1 + {3'b000, m[k]};
         rate_inc = base << r[3:2];
      end
   endfunction

endpackage

// File: rtl/fm_env_rate.sv
module fm_env_rate
   import fm_env_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [4:0]       raw_rate,
   input  logic [1:0]       ks_sel,
   input  logic [4:0]       keycode,
   input  logic [CNT_W-1:0] env_cnt,
   output logic [5:0]       eff_rate,
   output logic             gate_ok,
   output logic [3:0]       inc
);

   localparam int SH_W = 4;

   logic [1:0]       ks_shift;
   logic [4:0]       ks_add;
   logic [6:0]       scaled;
   logic [SH_W-1:0]  s_amt;
   logic [CNT_W-1:0] low_mask;
   logic [CNT_W-1:0] shifted;

   always_comb begin
      ks_shift = 2'd3 - ks_sel;
      ks_add   = keycode >> ks_shift;
      scaled   = {1'b0, raw_rate, 1'b0} + {2'b00, ks_add};
      if (raw_rate == 5'd0)
         eff_rate = 6'd0;
      else if (scaled > 7'd63)
         eff_rate = 6'd63;
      else
         eff_rate = scaled[5:0];
   end

   always_comb begin
      if (eff_rate < 6'd48)
         s_amt = SH_W'((6'd47 - eff_rate) >> 2);
      else
         s_amt = '0;
      low_mask = (CNT_W'(1) << s_amt) - CNT_W'(1);
      gate_ok  = ((env_cnt & low_mask) == '0);
      shifted  = env_cnt >> s_amt;
      inc      = rate_inc(eff_rate, shifted[2:0]);
   end

endmodule

// File: rtl/fm_env_step.sv
module fm_env_step
   import fm_env_pkg::*;
(
   input  env_phase_t       act_ph,
   input  logic [ENV_W-1:0] cur_env,
   input  logic             key_on,
   input  logic             key_off,
   input  logic [5:0]       eff_rate,
   input  logic             gate_ok,
   input  logic [3:0]       inc,
   output env_phase_t       nxt_ph,
   output logic [ENV_W-1:0] nxt_env
);

   logic [ENV_W+3:0] prod;
   logic [ENV_W+3:0] drop;
   logic [ENV_W:0]   sum;

   always_comb begin
      prod    = {4'b0000, cur_env} * {{ENV_W{1'b0}}, inc};
      drop    = (prod >> 4) + (ENV_W+4)'(1);
      sum     = {1'b0, cur_env} + {{(ENV_W-3){1'b0}}, inc};
      nxt_ph  = act_ph;
      nxt_env = cur_env;
      if (key_on) begin
         if (eff_rate >= 6'd62) begin
            nxt_env = '0;
            nxt_ph  = PH_DEC;
         end else begin
            nxt_ph  = PH_ATK;
         end
      end else if (key_off) begin
         nxt_ph = PH_REL;
      end else if (act_ph == PH_ATK) begin
         if (gate_ok && inc != 4'd0) begin
            if (drop >= {4'b0000, cur_env})
               nxt_env = '0;
            else
               nxt_env = cur_env - drop[ENV_W-1:0];
         end
         if (nxt_env == '0)
            nxt_ph = PH_DEC;
      end else if (gate_ok) begin
         if (sum > {1'b0, ENV_MAX})
            nxt_env = ENV_MAX;
         else
            nxt_env = sum[ENV_W-1:0];
      end
   end

endmodule

// File: rtl/fm_env_store.sv
module fm_env_store
   import fm_env_pkg::*;
#(
   parameter int NUM_OPS = 24,
   parameter int OP_W    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OP_W-1:0]  wr_idx,
   input  env_phase_t       wr_ph,
   input  logic [ENV_W-1:0] wr_env,
   input  logic [OP_W-1:0]  rd_idx,
   output env_phase_t       rd_ph,
   output logic [ENV_W-1:0] rd_env
);

   env_phase_t       ph_v  [NUM_OPS];
   logic [ENV_W-1:0] env_v [NUM_OPS];

   for (genvar g = 0; g < NUM_OPS; g++) begin : g_slot
      env_phase_t       ph_r;
      logic [ENV_W-1:0] env_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph_r  <= PH_REL;
            env_r <= ENV_MAX;
         end else if (wr_en && (wr_idx == OP_W'(g))) begin
            ph_r  <= wr_ph;
            env_r <= wr_env;
         end
      end
      assign ph_v[g]  = ph_r;
      assign env_v[g] = env_r;
   end

   always_comb begin
      rd_ph  = PH_REL;
      rd_env = ENV_MAX;
      if (32'(rd_idx) < NUM_OPS) begin
         rd_ph  = ph_v[rd_idx];
         rd_env = env_v[rd_idx];
      end
   end

endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
   import fm_env_pkg::*;
#(
   parameter int NUM_OPS = 24,
   parameter int CNT_W   = 16,
   localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic [OP_W-1:0]  upd_op,
   input  logic             key_on,
   input  logic             key_off,
   input  logic [4:0]       atk_rate,
   input  logic [4:0]       dec_rate,
   input  logic [4:0]       sus_rate,
   input  logic [3:0]       rel_field,
   input  logic [3:0]       sus_field,
   input  logic [1:0]       ks_sel,
   input  logic [4:0]       keycode,
   input  logic [CNT_W-1:0] env_cnt,
   output logic [9:0]       env_out,
   output logic [1:0]       out_phase,
   output logic [OP_W-1:0]  out_op,
   output logic             out_valid
);

   // widest gate shift is 11, plus 3 step bits
   localparam int MIN_CNT_W = 14;

   if (CNT_W < MIN_CNT_W) begin : g_chk_cnt
      $error("fm_env_gen: CNT_W must be at least 14");
   end
   if (NUM_OPS < 1) begin : g_chk_ops
      $error("fm_env_gen: NUM_OPS must be positive");
   end

   env_phase_t       rd_ph;
   logic [ENV_W-1:0] rd_env;
   env_phase_t       act_ph;
   logic [ENV_W-1:0] sus_lvl;
   logic [4:0]       raw_sel;
   logic [5:0]       eff_rate;
   logic             gate_ok;
   logic [3:0]       inc;
   env_phase_t       nxt_ph;
   logic [ENV_W-1:0] nxt_env;

   fm_env_store #(.NUM_OPS(NUM_OPS), .OP_W(OP_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (upd_en),
      .wr_idx (upd_op),
      .wr_ph  (nxt_ph),
      .wr_env (nxt_env),
      .rd_idx (upd_op),
      .rd_ph  (rd_ph),
      .rd_env (rd_env)
   );

   always_comb begin
      sus_lvl = (sus_field == 4'hF) ? ENV_MAX : {1'b0, sus_field, 5'b00000};
      act_ph  = (rd_ph == PH_DEC && rd_env >= sus_lvl) ? PH_SUS : rd_ph;
      if (key_on) begin
         raw_sel = atk_rate;
      end else begin
         case (act_ph)
            PH_ATK:  raw_sel = atk_rate;
            PH_DEC:  raw_sel = dec_rate;
            PH_SUS:  raw_sel = sus_rate;
            default: raw_sel = {rel_field, 1'b1};
         endcase
      end
   end

   fm_env_rate #(.CNT_W(CNT_W)) u_rate (
      .raw_rate (raw_sel),
      .ks_sel   (ks_sel),
      .keycode  (keycode),
      .env_cnt  (env_cnt),
      .eff_rate (eff_rate),
      .gate_ok  (gate_ok),
      .inc      (inc)
   );

   fm_env_step u_step (
      .act_ph   (act_ph),
      .cur_env  (rd_env),
      .key_on   (key_on),
      .key_off  (key_off),
      .eff_rate (eff_rate),
      .gate_ok  (gate_ok),
      .inc      (inc),
      .nxt_ph   (nxt_ph),
      .nxt_env  (nxt_env)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         env_out   <= ENV_MAX;
         out_phase <= PH_REL;
         out_op    <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= upd_en;
         if (upd_en) begin
            env_out   <= nxt_env;
            out_phase <= nxt_ph;
            out_op    <= upd_op;
         end
      end
   end

endmodule

// File: rtl/fm_env_gen_chk.sv
module fm_env_gen_chk #(
   parameter int OP_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            upd_en,
   input logic [OP_W-1:0] upd_op,
   input logic            key_on,
   input logic            key_off,
   input logic [9:0]      env_out,
   input logic [1:0]      out_phase,
   input logic [OP_W-1:0] out_op,
   input logic            out_valid,
   input logic [1:0]      rd_ph,
   input logic [9:0]      rd_env,
   input logic            gate_ok
);

   a_r2_strobe_echo: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (out_valid && out_op == $past(upd_op)));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> (!out_valid && $stable(env_out)));

   a_r10_keyoff_release: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && key_off && !key_on) |=> (out_phase == 2'd3 && env_out == $past(rd_env)));

   a_r10_keyon_start: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && key_on) |=> (out_phase == 2'd0 && env_out == $past(rd_env)) ||
                              (out_phase == 2'd1 && env_out == 10'd0));

   a_r6_attack_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !key_on && !key_off && rd_ph == 2'd0) |=> (env_out <= $past(rd_env)));

   a_r7_other_rises: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !key_on && !key_off && rd_ph != 2'd0) |=> (env_out >= $past(rd_env)));

   a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !key_on && !key_off && !gate_ok) |=> (env_out == $past(rd_env)));

endmodule

bind fm_env_gen fm_env_gen_chk #(.OP_W(OP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .upd_en    (upd_en),
   .upd_op    (upd_op),
   .key_on    (key_on),
   .key_off   (key_off),
   .env_out   (env_out),
   .out_phase (out_phase),
   .out_op    (out_op),
   .out_valid (out_valid),
   .rd_ph     (rd_ph),
   .rd_env    (rd_env),
   .gate_ok   (gate_ok)
);

// File: tb/fm_env_gen_test.sv
module fm_env_gen_test;

   localparam int NUM_OPS = 24;
   localparam int CNT_W   = 16;
   localparam int OP_W    = $clog2(NUM_OPS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             upd_en = 1'b0;
   logic [OP_W-1:0]  upd_op = '0;
   logic             key_on = 1'b0, key_off = 1'b0;
   logic [4:0]       atk_rate = '0, dec_rate = '0, sus_rate = '0;
   logic [3:0]       rel_field = '0, sus_field = '0;
   logic [1:0]       ks_sel = '0;
   logic [4:0]       keycode = '0;
   logic [CNT_W-1:0] env_cnt = '0;
   logic [9:0]       env_out;
   logic [1:0]       out_phase;
   logic [OP_W-1:0]  out_op;
   logic             out_valid;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 0;

   always #2 clk = ~clk;

   fm_env_gen #(.NUM_OPS(NUM_OPS), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_op(upd_op),
      .key_on(key_on), .key_off(key_off), .atk_rate(atk_rate),
      .dec_rate(dec_rate), .sus_rate(sus_rate), .rel_field(rel_field),
      .sus_field(sus_field), .ks_sel(ks_sel), .keycode(keycode),
      .env_cnt(env_cnt), .env_out(env_out), .out_phase(out_phase),
      .out_op(out_op), .out_valid(out_valid)
   );

   // ---------------- reference model ----------------
   int m_ph  [NUM_OPS];
   int m_env [NUM_OPS];
   int x_env = 1023, x_ph = 3, x_op = 0;
   bit x_valid = 0;

   int lo_tab [4][8] = '{'{0,1,0,1,0,1,0,1}, '{0,1,0,1,1,1,0,1},
                         '{0,1,1,1,0,1,1,1}, '{0,1,1,1,1,1,1,1}};
   int hi_tab [4][8] = '{'{1,1,1,1,1,1,1,1}, '{1,1,1,2,1,1,1,2},
                         '{1,2,1,2,1,2,1,2}, '{1,2,2,2,1,2,2,2}};

   function automatic int m_eff(int r, int ks, int kc);
      int v;
      if (r == 0) return 0;
      v = 2 * r + (kc >> (3 - ks));
      return (v > 63) ? 63 : v;
   endfunction

   function automatic int m_inc(int er, int cnt);
      int s, st;
      s = (er < 48) ? (47 - er) / 4 : 0;
      if ((cnt % (1 << s)) != 0) return 0;
      st = (cnt >> s) % 8;
      if (er < 2) return 0;
      if (er >= 60) return 8;
      if (er < 8) return lo_tab[((er / 2) % 4 == 3) ? 2 : 0][st];
      if (er < 48) return lo_tab[er % 4][st];
      return hi_tab[er % 4][st] * (1 << ((er - 48) / 4));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_OPS; i++) begin m_ph[i] = 3; m_env[i] = 1023; end
         x_valid = 0; x_env = 1023; x_ph = 3; x_op = 0;
      end else begin
         x_valid = upd_en;
         if (upd_en) begin
            int o, p, e, sl, r, i, d;
            o = int'(upd_op); p = m_ph[o]; e = m_env[o];
            if (key_on) begin
               if (m_eff(atk_rate, ks_sel, keycode) >= 62) begin e = 0; p = 1; end
               else p = 0;
            end else if (key_off) begin
               p = 3;
            end else begin
               sl = (sus_field == 15) ? 1023 : int'(sus_field) * 32;
               if (p == 1 && e >= sl) p = 2;
               case (p)
                  0: r = atk_rate;
                  1: r = dec_rate;
                  2: r = sus_rate;
                  default: r = int'(rel_field) * 2 + 1;
               endcase
               i = m_inc(m_eff(r, ks_sel, keycode), int'(env_cnt));
               if (p == 0) begin
                  if (i != 0) begin
                     d = (e * i) / 16 + 1;
                     e = (d >= e) ? 0 : e - d;
                  end
                  if (e == 0) p = 1;
               end else begin
                  e = (e + i > 1023) ? 1023 : e + i;
               end
            end
            m_ph[o] = p; m_env[o] = e;
            x_env = e; x_ph = p; x_op = o;
         end
      end
   end

   task automatic chk(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model (R2 R5 R6 R7)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 valid", int'(out_valid), int'(x_valid));
         if (x_valid) begin
            chk("R2 op", int'(out_op), x_op);
            chk("R5/R6/R7 model env", int'(env_out), x_env);
            chk("R6/R8 model phase", int'(out_phase), x_ph);
         end
      end
   end

   task automatic strobe(int op, bit kon, bit koff, int cnt);
      upd_op = OP_W'(op); key_on = kon; key_off = koff;
      env_cnt = CNT_W'(cnt); upd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      upd_en = 1'b0; key_on = 1'b0; key_off = 1'b0;
   endtask

   task automatic expect_out(string tag, int e, int p);
      chk({tag, " env"}, int'(env_out), e);
      chk({tag, " phase"}, int'(out_phase), p);
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles >= 200000 && !done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned rs;
      repeat (3) @(negedge clk);
      // R1 reset outputs
      chk("R1 reset env", int'(env_out), 1023);
      chk("R1 reset phase", int'(out_phase), 3);
      chk("R1 reset valid", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: stored reset state seen on an idle strobe (release field 0 -> rate 2, inc 0)
      strobe(3, 0, 0, 0);
      expect_out("R1 stored state", 1023, 3);
      @(negedge clk);
      chk("R2 idle valid low", int'(out_valid), 0);
      chk("R2 idle hold", int'(env_out), 1023);

      // R10: instant attack, rate 31 ks3 kc31 -> 63
      atk_rate = 5'd31; ks_sel = 2'd3; keycode = 5'd31;
      strobe(0, 1, 0, 0);
      expect_out("R10 fast keyon", 0, 1);

      // R10: normal key-on keeps attenuation
      atk_rate = 5'd10; ks_sel = 2'd0; keycode = 5'd0;
      strobe(1, 1, 0, 0);
      expect_out("R10 keyon attack", 1023, 0);

      // R6: eff 20, S=6, cnt 64 -> step 1, inc 1: 1023-63-1
      strobe(1, 0, 0, 64);
      expect_out("R6 attack step", 959, 0);

      // R4: cnt 65 has low bits set -> no change
      strobe(1, 0, 0, 65);
      expect_out("R4 gate closed", 959, 0);

      // R5: eff 52 -> hi0 shifted by 1 -> inc 2: 959-119-1
      atk_rate = 5'd26; ks_sel = 2'd3; keycode = 5'd0;
      strobe(1, 0, 0, 3);
      expect_out("R5 high pattern", 839, 0);

      // R7: decay at eff 63 adds 8
      dec_rate = 5'd31; ks_sel = 2'd3; keycode = 5'd31; sus_field = 4'd15;
      strobe(0, 0, 0, 5);
      expect_out("R7 decay add", 8, 1);

      // R8: sustain level 0 -> switch to sustain, sustain rate 0 -> no change
      sus_field = 4'd0; sus_rate = 5'd0;
      strobe(0, 0, 0, 0);
      expect_out("R8 to sustain", 8, 2);

      // R10: key-off
      strobe(0, 0, 1, 0);
      expect_out("R10 keyoff", 8, 3);

      // R9: release field 15 -> raw 31 -> eff 63 -> +8
      rel_field = 4'd15;
      strobe(0, 0, 0, 7);
      expect_out("R9 release rate", 16, 3);

      // R7: saturation at 1023
      for (int k = 0; k < 130; k++) strobe(0, 0, 0, k);
      expect_out("R7 saturate", 1023, 3);

      // R11: op1 untouched by op0 traffic (attack rate 0 -> no step)
      atk_rate = 5'd0;
      strobe(1, 0, 0, 0);
      expect_out("R11 independence", 839, 0);

      // R10: both keys -> key-on wins
      strobe(0, 1, 1, 0);
      expect_out("R10 keyon priority", 1023, 0);

      // R3: key scaling
      atk_rate = 5'd29; ks_sel = 2'd2; keycode = 5'd16;
      strobe(4, 1, 0, 0);
      expect_out("R3 scaled saturates", 0, 1);
      ks_sel = 2'd0;
      strobe(5, 1, 0, 0);
      expect_out("R3 scaled to 60", 1023, 0);

      // mixed traffic against the model (R3 R4 R5 R6 R7 R8 R9 R11)
      rs = 32'h1234_5679;
      for (int k = 0; k < 4000; k++) begin
         int o;
         rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
         o = int'(rs % NUM_OPS);
         atk_rate  = rs[8:4];   dec_rate = rs[13:9];  sus_rate = rs[18:14];
         rel_field = rs[22:19]; sus_field = rs[26:23];
         ks_sel    = rs[28:27]; keycode   = rs[12:8];
         strobe(o, rs[31:29] == 3'd0, rs[31:29] == 3'd1, k);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule